// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts return targets for a pipelined fetch unit. It keeps a fixed number of return addresses in a ring of registers, with a top-of-stack pointer that wraps at both ends. When fetch sees a call it pushes the return address. When it sees a return it pops. The address at the top of the ring is always shown on an output, together with the pointer itself. Fetch can therefore predict a return target and keep the pointer as a checkpoint.

A separate restore port repairs the stack after a misprediction. It takes a previously saved index and a corrected address. The pointer jumps to that index and the entry there is rewritten. An occupancy counter drives the empty and full flags. When the ring is full, further pushes overwrite the oldest entry; they are never refused.

Top module: `ret_addr_stack`

## Requirements
- R1: While reset is high at a rising edge, the pointer, the occupancy count and every entry are cleared to zero. After reset, the top address reads 0, the top index reads 0, empty is 1 and full is 0.
- R2: A push alone first advances the pointer by one, then stores the push address at the new top. From the next cycle the top address equals the pushed address and the top index equals the advanced pointer.
- R3: A push when the pointer is NUM_ENTRIES-1 moves the pointer to 0.
- R4: A pop alone moves the pointer down by one, and a pop at 0 moves it to NUM_ENTRIES-1. The occupancy count drops by one but stays at 0 if it is already 0. A pop while empty still moves the pointer.
- R5: A restore with index below NUM_ENTRIES sets the pointer to that index and writes the restore address into that entry. The occupancy count is unchanged. A valid restore takes priority over a push or pop in the same cycle.
- R6: Empty is 1 exactly when the occupancy count is 0, and full is 1 exactly when it equals NUM_ENTRIES. A push raises the count by one, up to a limit of NUM_ENTRIES. A push while full overwrites the oldest entry and still moves the pointer.
- R7: A push and a pop together, with no valid restore, write the push address into the current top entry. The pointer and the occupancy count do not change.
- R8: A restore whose index is NUM_ENTRIES or above has no effect. Any push or pop in the same cycle acts as if no restore were requested.
- R9: The top address is always the entry at the current top index. It is read combinationally from registered state, and a change on an input shows only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request (call seen) |
| push_addr_i | input | ADDR_W | Return address to push |
| pop_i | input | 1 | Pop request (return seen) |
| restore_i | input | 1 | Restore request after a misprediction |
| restore_idx_i | input | IDX_W | Saved top index to rewind to |
| restore_addr_i | input | ADDR_W | Corrected address for the restored entry |
| top_addr_o | output | ADDR_W | Entry at the current top index |
| top_idx_o | output | IDX_W | Current top-of-stack index |
| empty_o | output | 1 | Occupancy count is zero |
| full_o | output | 1 | Occupancy count equals NUM_ENTRIES |

## Verification
Two situations are hard to reach from the ports. One is the overwrite of the oldest entry once the count has saturated. The other is the ring pointer wrapping in both directions while the count stays pinned at a limit. To reach them, the stimulus pushes more than NUM_ENTRIES addresses in a row. It then pops past empty, so the pointer keeps moving while the count is held at zero. With a default depth that is not a power of two, the restore port can be driven with index values the ring cannot hold, which shows that those requests are ignored. A final sweep restores every index in turn and reads back each entry through the top address.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [2:0] {
        RAS_HOLD   = 3'd0,
        RAS_PUSH   = 3'd1,
        RAS_POP    = 3'd2,
        RAS_SWAP   = 3'd3,
        RAS_REWIND = 3'd4
    } ras_op_e;

    typedef struct packed {
        ras_op_e op;
        logic    wr_en;
        logic    use_restore_data;
    } ras_cmd_t;

    function automatic int unsigned ring_inc(input int unsigned p, input int unsigned n);
        return (p == n - 1) ? 0 : p + 1;
    endfunction

    function automatic int unsigned ring_dec(input int unsigned p, input int unsigned n);
        return (p == 0) ? n - 1 : p - 1;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             restore_i,
    input  logic [IDX_W-1:0] restore_idx_i,
    output ras_cmd_t         cmd_o
);
    localparam int LIMIT = NUM_ENTRIES;

    logic idx_ok;

    always_comb begin
        idx_ok = (int'(restore_idx_i) < LIMIT);
        cmd_o  = '{op: RAS_HOLD, wr_en: 1'b0, use_restore_data: 1'b0};
        if (restore_i && idx_ok) begin
            cmd_o.op               = RAS_REWIND;
            cmd_o.wr_en            = 1'b1;
            cmd_o.use_restore_data = 1'b1;
        end else if (push_i && pop_i) begin
            cmd_o.op    = RAS_SWAP;
            cmd_o.wr_en = 1'b1;
        end else if (push_i) begin
            cmd_o.op    = RAS_PUSH;
            cmd_o.wr_en = 1'b1;
        end else if (pop_i) begin
            cmd_o.op = RAS_POP;
        end
    end

endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
    import ras_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int IDX_W       = $clog2(NUM_ENTRIES),
    parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  ras_op_e          op_i,
    input  logic [IDX_W-1:0] restore_idx_i,
    output logic [IDX_W-1:0] tos_o,
    output logic [IDX_W-1:0] nxt_tos_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_ENTRIES);
    localparam logic [IDX_W-1:0] LAST    = IDX_W'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0] tos_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        nxt_tos_o = tos_q;
        cnt_d     = cnt_q;
        unique case (op_i)
            RAS_PUSH: begin
                nxt_tos_o = IDX_W'(ring_inc(int'(tos_q), NUM_ENTRIES));
                cnt_d     = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            end
            RAS_POP: begin
                nxt_tos_o = IDX_W'(ring_dec(int'(tos_q), NUM_ENTRIES));
                cnt_d     = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
            end
            RAS_REWIND: nxt_tos_o = restore_idx_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            cnt_q <= '0;
        end else begin
            tos_q <= nxt_tos_o;
            cnt_q <= cnt_d;
        end
    end

    assign tos_o   = tos_q;
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_MAX);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(empty_o && full_o)); // R6
    AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_i == RAS_PUSH && tos_q == LAST) |=> tos_q == '0); // R3
    AST_POP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_i == RAS_POP && tos_q == '0) |=> tos_q == LAST); // R4
    AST_POP_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (op_i == RAS_POP && cnt_q == '0) |=> cnt_q == '0); // R4
    AST_REWIND_PTR: assert property (@(posedge clk) disable iff (rst)
        (op_i == RAS_REWIND) |=> (tos_q == $past(restore_idx_i) && $stable(cnt_q))); // R5

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int NUM_ENTRIES = 12,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);
    logic [ADDR_W-1:0] slot_q [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_ENTRIES; k++) slot_q[k] <= '0;
        end else if (wr_en_i) begin
            for (int k = 0; k < NUM_ENTRIES; k++) begin
                if (wr_idx_i == IDX_W'(k)) slot_q[k] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (rd_idx_i == IDX_W'(k)) rd_data_o = slot_q[k];
        end
    end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = $clog2(NUM_ENTRIES),
    parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    input  logic              restore_i,
    input  logic [IDX_W-1:0]  restore_idx_i,
    input  logic [ADDR_W-1:0] restore_addr_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [IDX_W-1:0]  top_idx_o,
    output logic              empty_o,
    output logic              full_o
);
    ras_cmd_t          cmd;
    logic [IDX_W-1:0]  tos;
    logic [IDX_W-1:0]  nxt_tos;
    logic [ADDR_W-1:0] wr_data;

    ras_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
        .push_i        (push_i),
        .pop_i         (pop_i),
        .restore_i     (restore_i),
        .restore_idx_i (restore_idx_i),
        .cmd_o         (cmd)
    );

    ras_ptr #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
        .clk           (clk),
        .rst           (rst),
        .op_i          (cmd.op),
        .restore_idx_i (restore_idx_i),
        .tos_o         (tos),
        .nxt_tos_o     (nxt_tos),
        .empty_o       (empty_o),
        .full_o        (full_o)
    );

    assign wr_data = cmd.use_restore_data ? restore_addr_i : push_addr_i;

    ras_store #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (cmd.wr_en),
        .wr_idx_i  (nxt_tos),
        .wr_data_i (wr_data),
        .rd_idx_i  (tos),
        .rd_data_o (top_addr_o)
    );

    assign top_idx_o = tos;

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !restore_i) |=> top_addr_o == $past(push_addr_i)); // R2
    AST_REWIND_TOP: assert property (@(posedge clk) disable iff (rst)
        (restore_i && int'(restore_idx_i) < NUM_ENTRIES)
        |=> (top_idx_o == $past(restore_idx_i) && top_addr_o == $past(restore_addr_i))); // R5
    AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !restore_i)
        |=> ($stable(top_idx_o) && $stable(empty_o) && $stable(full_o)
             && top_addr_o == $past(push_addr_i))); // R7
    AST_BAD_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (restore_i && int'(restore_idx_i) >= NUM_ENTRIES && !push_i && !pop_i)
        |=> ($stable(top_idx_o) && $stable(top_addr_o))); // R8

endmodule

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
    localparam int N  = 12;
    localparam int AW = 32;
    localparam int IW = $clog2(N);

    typedef struct {
        logic [AW-1:0] addr;
        int            idx;
        bit            empty;
        bit            full;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_i = 1'b0, pop_i = 1'b0, restore_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0, restore_addr_i = '0;
    logic [IW-1:0] restore_idx_i = '0;
    logic [AW-1:0] top_addr_o;
    logic [IW-1:0] top_idx_o;
    logic          empty_o, full_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [AW-1:0] m_mem [N];
    int            m_tos;
    int            m_cnt;
    exp_t          sb_q [$];

    always #4 clk = ~clk;

    ret_addr_stack #(.NUM_ENTRIES(N), .ADDR_W(AW)) u_ret_addr_stack (
        .clk(clk), .rst(rst),
        .push_i(push_i), .push_addr_i(push_addr_i), .pop_i(pop_i),
        .restore_i(restore_i), .restore_idx_i(restore_idx_i),
        .restore_addr_i(restore_addr_i),
        .top_addr_o(top_addr_o), .top_idx_o(top_idx_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic compare(input exp_t e);
        tests++;
        if (top_addr_o !== e.addr || int'(top_idx_o) != e.idx ||
            empty_o !== e.empty || full_o !== e.full) begin
            fails++;
            $display("FAIL %s: got addr=%h idx=%0d empty=%b full=%b, expected addr=%h idx=%0d empty=%b full=%b",
                     e.tag, top_addr_o, top_idx_o, empty_o, full_o,
                     e.addr, e.idx, e.empty, e.full);
        end
    endtask

    task automatic step(input bit pu, input bit po, input logic [AW-1:0] a,
                        input bit rs, input int ri, input logic [AW-1:0] ra,
                        input string tag);
        exp_t e;
        push_i = pu; pop_i = po; push_addr_i = a;
        restore_i = rs; restore_idx_i = IW'(ri); restore_addr_i = ra;
        if (rs && ri < N) begin
            m_tos = ri; m_mem[ri] = ra;
        end else if (pu && po) begin
            m_mem[m_tos] = a;
        end else if (pu) begin
            m_tos = (m_tos == N - 1) ? 0 : m_tos + 1;
            m_mem[m_tos] = a;
            if (m_cnt < N) m_cnt++;
        end else if (po) begin
            m_tos = (m_tos == 0) ? N - 1 : m_tos - 1;
            if (m_cnt > 0) m_cnt--;
        end
        e.addr = m_mem[m_tos]; e.idx = m_tos;
        e.empty = (m_cnt == 0); e.full = (m_cnt == N); e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares just after each rising edge that committed a step
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    initial begin
        exp_t r;
        for (int k = 0; k < N; k++) m_mem[k] = '0;
        m_tos = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        r.addr = '0; r.idx = 0; r.empty = 1'b1; r.full = 1'b0; r.tag = "R1";
        compare(r);

        step(0, 1, '0, 0, 0, '0, "R4");          // pop while empty: 0 -> N-1
        step(0, 0, '0, 0, 0, '0, "R9");          // idle, no change
        step(1, 0, 32'h1000, 0, 0, '0, "R3");    // N-1 -> 0
        for (int i = 0; i < N + 2; i++)
            step(1, 0, 32'h2000 + 32'(i * 4), 0, 0, '0, "R6");
        step(1, 0, 32'h3000, 0, 0, '0, "R2");
        for (int i = 0; i < 3; i++) step(0, 1, '0, 0, 0, '0, "R4");
        step(1, 1, 32'h4444, 0, 0, '0, "R7");
        step(1, 0, 32'h5555, 1, 5, 32'h5A5A, "R5");
        step(0, 1, '0, 1, 5, 32'h6B6B, "R5");
        step(0, 1, '0, 1, 14, 32'h7777, "R8");
        step(0, 0, '0, 1, 13, 32'h8888, "R8");
        step(1, 0, 32'h9999, 1, 15, 32'h1111, "R8");
        for (int i = 0; i < N + 3; i++) step(0, 1, '0, 0, 0, '0, "R4");
        for (int i = 0; i < N; i++) step(0, 0, '0, 1, i, 32'hA000 + 32'(i), "R9");
        step(1, 0, 32'hBEEF, 0, 0, '0, "R2");
        step(0, 0, '0, 0, 0, '0, "R9");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule